// File: doc/BRIEF.md
# Paired-Lane Vector Carry-Chain Adder

This block is the arithmetic slice of a scalable vector unit that runs one wide add-with-carry step. It receives three operand vectors of a configurable total width: an accumulator that is also the destination, a first source, and a carry vector. It splits them into neighbouring even/odd lane pairs. For each pair, the even accumulator lane is added to the odd first-source lane, together with a single carry bit taken from the odd lane of the carry vector. The truncated sum replaces the even lane. The carry produced by that add fills the odd lane as a zero-extended value. Chaining such steps builds arithmetic that is wider than one lane.

A one-bit size selector chooses 32-bit or 64-bit lanes. Requests enter with a valid strobe, and the packed result comes back exactly one clock later. The latency never depends on operand values. An optional front-end decoder checks a 32-bit operation word against a fixed bit pattern. It takes the lane size and three register indices from that word. A word that does not match is flagged as illegal and produces no result.

Top module: `pair_adc_unit`

## Requirements
- R1: Lanes are 32 bits when the size bit is 0 and 64 bits when it is 1. VLEN must be a multiple of 128, and all VLEN/(2*lane) pairs are computed. Lane k occupies bits [k*lane +: lane].
- R2: Destination lane 2p equals (accumulator lane 2p + first-source lane 2p+1 + carry-in) modulo 2^lane.
- R3: The carry-in of pair p is bit 0 of carry-vector lane 2p+1. Every other bit of the carry vector has no effect on the result.
- R4: Destination lane 2p+1 holds the unsigned carry-out of pair p in bit 0, with all of its other bits zero.
- R5: out_valid is high exactly in the cycle after an accepted request, with a latency of one clock that does not depend on the data. With no request, out_valid is low and out_result keeps its value.
- R6: Active-low reset clears out_valid, out_illegal, out_result and the three index outputs to zero.
- R7: With the decoder enabled, a word is accepted only if bits [31:23]=010001010, bit 21=0 and bits [15:10]=110101. Bit 22 is then the size bit and in_size is ignored.
- R8: On acceptance, the carry index [20:16], the first-source index [9:5] and the destination index [4:0] appear on out_car_idx, out_src_idx and out_dst_idx together with out_valid.
- R9: A request whose word does not match raises out_illegal for one cycle one clock later. out_valid stays low, and out_result and the index outputs keep their previous values.
- R10: Accumulator odd lanes and first-source even lanes have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request strobe |
| in_size | input | 1 | Lane size when the decoder is disabled (0: 32-bit, 1: 64-bit) |
| in_instr | input | 32 | Operation word checked by the decoder |
| in_acc | input | VLEN | Accumulator/destination vector |
| in_src | input | VLEN | First source vector |
| in_car | input | VLEN | Carry source vector |
| out_valid | output | 1 | Result valid, one cycle after an accepted request |
| out_illegal | output | 1 | Rejected operation word, one cycle after the request |
| out_result | output | VLEN | Packed sums and carries |
| out_dst_idx | output | 5 | Destination register index |
| out_src_idx | output | 5 | First-source register index |
| out_car_idx | output | 5 | Carry-vector register index |

## Verification
The operation result and the rejection of a malformed word share the same output register stage. An illegal word arriving one cycle after a legal one, or just before it, shows whether a rejection leaves the previous result and indices intact. It also shows whether the two flags ever overlap. The bench drives such back-to-back legal/illegal sequences at both lane sizes. Every clock, it compares the valid flag, the illegal flag, the held result and the indices against a behavioural model that keeps the last accepted values.

// File: rtl/vpair_pkg.sv
package vpair_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned IDX_W    = 5;
   localparam int unsigned PAIR_GRAN = 128;

   localparam logic [8:0] OPC_TOP = 9'b010001010;
   localparam logic [5:0] OPC_MID = 6'b110101;

   typedef struct packed {
      logic             wide;
      logic [IDX_W-1:0] car_idx;
      logic [IDX_W-1:0] src_idx;
      logic [IDX_W-1:0] dst_idx;
   } op_fields_t;

endpackage

// File: rtl/vpair_decode.sv
module vpair_decode
   import vpair_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   output logic              hit,
   output op_fields_t        fields
);

   logic top_ok;
   logic mid_ok;
   logic fix_ok;

   assign top_ok = (word[31:23] == OPC_TOP);
   assign mid_ok = (word[15:10] == OPC_MID);
   assign fix_ok = (word[21] == 1'b0);
   assign hit    = top_ok & mid_ok & fix_ok;

   assign fields.wide    = word[22];
   assign fields.car_idx = word[20:16];
   assign fields.src_idx = word[9:5];
   assign fields.dst_idx = word[4:0];

endmodule

// File: rtl/vpair_lane.sv
module vpair_lane #(
   parameter int unsigned LW = 32
) (
   input  logic [LW-1:0]   aug,
   input  logic [LW-1:0]   add,
   input  logic            cin,
   output logic [2*LW-1:0] pair_q
);

   logic [LW:0] total;

   assign total  = {1'b0, aug} + {1'b0, add} + {{LW{1'b0}}, cin};
   assign pair_q = {{(LW-1){1'b0}}, total[LW], total[LW-1:0]};

endmodule

// File: rtl/vpair_datapath.sv
module vpair_datapath #(
   parameter int unsigned VLEN = 256
) (
   input  logic            wide,
   input  logic [VLEN-1:0] acc,
   input  logic [VLEN-1:0] src,
   input  logic [VLEN-1:0] car,
   output logic [VLEN-1:0] res
);

   localparam int unsigned LW_N = 32;
   localparam int unsigned LW_W = 64;
   localparam int unsigned NP_N = VLEN / (2 * LW_N);
   localparam int unsigned NP_W = VLEN / (2 * LW_W);

   logic [VLEN-1:0] res_n;
   logic [VLEN-1:0] res_w;
   logic            unused_lanes;

   assign unused_lanes = ^{acc, src, car};

   for (genvar p = 0; p < NP_N; p++) begin : g_narrow
      vpair_lane #(.LW(LW_N)) u_lane (
         .aug    (acc[(2*p)*LW_N +: LW_N]),
         .add    (src[(2*p+1)*LW_N +: LW_N]),
         .cin    (car[(2*p+1)*LW_N]),
         .pair_q (res_n[(2*p)*LW_N +: 2*LW_N])
      );
   end

   for (genvar p = 0; p < NP_W; p++) begin : g_wide
      vpair_lane #(.LW(LW_W)) u_lane (
         .aug    (acc[(2*p)*LW_W +: LW_W]),
         .add    (src[(2*p+1)*LW_W +: LW_W]),
         .cin    (car[(2*p+1)*LW_W]),
         .pair_q (res_w[(2*p)*LW_W +: 2*LW_W])
      );
   end

   assign res = wide ? res_w : res_n;

endmodule

// File: rtl/pair_adc_unit.sv
module pair_adc_unit
   import vpair_pkg::*;
#(
   parameter int unsigned VLEN        = 256,
   parameter bit          USE_DECODER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_size,
   input  logic [WORD_W-1:0] in_instr,
   input  logic [VLEN-1:0]   in_acc,
   input  logic [VLEN-1:0]   in_src,
   input  logic [VLEN-1:0]   in_car,
   output logic              out_valid,
   output logic              out_illegal,
   output logic [VLEN-1:0]   out_result,
   output logic [IDX_W-1:0]  out_dst_idx,
   output logic [IDX_W-1:0]  out_src_idx,
   output logic [IDX_W-1:0]  out_car_idx
);

   if ((VLEN % PAIR_GRAN) != 0 || VLEN == 0) begin : g_bad_vlen
      $error("pair_adc_unit: VLEN must be a non-zero multiple of 128");
   end

   logic             dec_ok;
   logic             eff_wide;
   logic [IDX_W-1:0] nxt_dst;
   logic [IDX_W-1:0] nxt_src;
   logic [IDX_W-1:0] nxt_car;
   logic [VLEN-1:0]  dp_res;
   logic             accept;
   logic             reject;

   if (USE_DECODER) begin : g_dec
      op_fields_t f;
      logic       unused_size;
      vpair_decode u_dec (
         .word   (in_instr),
         .hit    (dec_ok),
         .fields (f)
      );
      assign eff_wide    = f.wide;
      assign nxt_dst     = f.dst_idx;
      assign nxt_src     = f.src_idx;
      assign nxt_car     = f.car_idx;
      assign unused_size = in_size;
   end else begin : g_nodec
      logic unused_word;
      assign dec_ok      = 1'b1;
      assign eff_wide    = in_size;
      assign nxt_dst     = '0;
      assign nxt_src     = '0;
      assign nxt_car     = '0;
      assign unused_word = ^in_instr;
   end

   vpair_datapath #(.VLEN(VLEN)) u_dp (
      .wide (eff_wide),
      .acc  (in_acc),
      .src  (in_src),
      .car  (in_car),
      .res  (dp_res)
   );

   assign accept = in_valid & dec_ok;
   assign reject = in_valid & ~dec_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
         out_result  <= '0;
         out_dst_idx <= '0;
         out_src_idx <= '0;
         out_car_idx <= '0;
      end else begin
         out_valid   <= accept;
         out_illegal <= reject;
         if (accept) begin
            out_result  <= dp_res;
            out_dst_idx <= nxt_dst;
            out_src_idx <= nxt_src;
            out_car_idx <= nxt_car;
         end
      end
   end

   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dec_ok) |=> out_valid); // R5

   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_illegal && $stable(out_result))); // R5

   AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dec_ok) |=> (out_illegal && !out_valid && $stable(out_result) && $stable(out_dst_idx))); // R9

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && out_illegal)); // R9

endmodule

// File: tb/test_pair_adc_unit.sv
`timescale 1ns/1ps
module test_pair_adc_unit;

   localparam int unsigned VLEN = 256;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            in_valid;
   logic            in_size;
   logic [31:0]     in_instr;
   logic [VLEN-1:0] in_acc, in_src, in_car;
   logic            out_valid, out_illegal;
   logic [VLEN-1:0] out_result;
   logic [4:0]      out_dst_idx, out_src_idx, out_car_idx;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic            e_valid, e_ill;
   logic [VLEN-1:0] e_res;
   logic [4:0]      e_dst, e_src, e_car;
   string           e_tag;

   always #2.5 clk = ~clk;

   pair_adc_unit #(.VLEN(VLEN), .USE_DECODER(1'b1)) i_pair_adc_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_size(in_size),
      .in_instr(in_instr), .in_acc(in_acc), .in_src(in_src), .in_car(in_car),
      .out_valid(out_valid), .out_illegal(out_illegal), .out_result(out_result),
      .out_dst_idx(out_dst_idx), .out_src_idx(out_src_idx), .out_car_idx(out_car_idx)
   );

   function automatic logic [31:0] mk_word(input logic sz, input logic [4:0] d,
                                           input logic [4:0] s, input logic [4:0] c);
      return {9'b010001010, sz, 1'b0, c, 6'b110101, s, d};
   endfunction

   function automatic bit word_ok(input logic [31:0] w);
      return (w[31:23] == 9'h08A) && !w[21] && (w[15:10] == 6'h35);
   endfunction

   // Behavioural model: lane-by-lane 65-bit arithmetic
   function automatic logic [VLEN-1:0] model(input logic [VLEN-1:0] a, s, c, input logic sz);
      logic [VLEN-1:0] r = '0;
      int lw = sz ? 64 : 32;
      for (int p = 0; p < VLEN / (2 * lw); p++) begin
         logic [64:0] x, y, t;
         x = '0; y = '0;
         for (int b = 0; b < lw; b++) begin
            x[b] = a[2*p*lw + b];
            y[b] = s[(2*p+1)*lw + b];
         end
         t = x + y + 65'(c[(2*p+1)*lw]);
         for (int b = 0; b < lw; b++) r[2*p*lw + b] = t[b];
         r[(2*p+1)*lw] = t[lw];
      end
      return r;
   endfunction

   function automatic logic [VLEN-1:0] rnd_vec();
      logic [VLEN-1:0] v;
      for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare();
      chk("R5", "out_valid", VLEN'(out_valid), VLEN'(e_valid));
      chk("R9", "out_illegal", VLEN'(out_illegal), VLEN'(e_ill));
      chk(e_tag, "out_result", out_result, e_res);
      chk("R8", "indices", VLEN'({out_dst_idx, out_src_idx, out_car_idx}),
          VLEN'({e_dst, e_src, e_car}));
   endtask

   task automatic step(input logic v, input logic [31:0] w,
                       input logic [VLEN-1:0] a, s, c, input string tag);
      @(negedge clk);
      compare();
      in_valid = v; in_instr = w; in_acc = a; in_src = s; in_car = c;
      in_size  = ~w[22];            // R7: ignored when the decoder is present
      if (v && word_ok(w)) begin
         e_valid = 1; e_ill = 0;
         e_res = model(a, s, c, w[22]);
         e_dst = w[4:0]; e_src = w[9:5]; e_car = w[20:16];
         e_tag = tag;
      end else begin
         e_valid = 0; e_ill = v;
      end
   endtask

   task automatic idle();
      step(1'b0, 32'h0, rnd_vec(), rnd_vec(), rnd_vec(), e_tag);
   endtask

   // R10 helper: relevant lanes zeroed, irrelevant lanes random
   task automatic mask_run(input logic sz);
      logic [VLEN-1:0] a = rnd_vec(), s = rnd_vec(), c = '0;
      int lw = sz ? 64 : 32;
      for (int p = 0; p < VLEN / (2 * lw); p++)
         for (int b = 0; b < lw; b++) begin
            a[2*p*lw + b] = 1'b0;
            s[(2*p+1)*lw + b] = 1'b0;
         end
      step(1'b1, mk_word(sz, 5'd3, 5'd4, 5'd5), a, s, c, "R10");
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 0; in_valid = 0; in_size = 0; in_instr = '0;
      in_acc = '0; in_src = '0; in_car = '0;
      e_valid = 0; e_ill = 0; e_res = '0; e_dst = 0; e_src = 0; e_car = 0; e_tag = "R6";
      repeat (3) @(negedge clk);
      compare();                    // R6 reset state
      rst_n = 1;

      // R2 R4: all-ones operands with carry-in 1, both sizes
      step(1, mk_word(0, 5'd1, 5'd2, 5'd3), '1, '1, '1, "R4");
      step(1, mk_word(1, 5'd7, 5'd8, 5'd9), '1, '1, '1, "R4");
      // R2: zero operands
      step(1, mk_word(0, 5'd0, 5'd0, 5'd0), '0, '0, '0, "R2");
      step(1, mk_word(1, 5'd31, 5'd30, 5'd29), '0, '0, '0, "R2");
      idle();
      // R3: carry vector with every bit set except lane bit 0
      step(1, mk_word(0, 5'd10, 5'd11, 5'd12), '1, '1,
           ~{(VLEN/32){32'h1}}, "R3");
      step(1, mk_word(1, 5'd10, 5'd11, 5'd12), '1, '1,
           ~{(VLEN/64){64'h1}}, "R3");
      // R10: unused lanes carry random data
      mask_run(0);
      mask_run(1);
      // R7 R9: malformed words right after and before legal ones
      step(1, mk_word(0, 5'd1, 5'd1, 5'd1), rnd_vec(), rnd_vec(), rnd_vec(), "R9");
      step(1, mk_word(0, 5'd2, 5'd2, 5'd2) | 32'h0020_0000, rnd_vec(), rnd_vec(), rnd_vec(), "R9");
      step(1, mk_word(1, 5'd3, 5'd3, 5'd3) ^ 32'h4000_0000, rnd_vec(), rnd_vec(), rnd_vec(), "R7");
      step(1, mk_word(1, 5'd4, 5'd4, 5'd4) ^ 32'h0000_0400, rnd_vec(), rnd_vec(), rnd_vec(), "R7");
      idle();
      step(1, mk_word(1, 5'd6, 5'd7, 5'd8), rnd_vec(), rnd_vec(), rnd_vec(), "R7");
      // R1 R5: random data, both sizes, back-to-back and with gaps
      for (int i = 0; i < 200; i++) begin
         logic sz = 1'($urandom);
         step(1, mk_word(sz, 5'($urandom), 5'($urandom), 5'($urandom)),
              rnd_vec(), rnd_vec(), rnd_vec(), "R1");
         if (($urandom % 4) == 0) idle();
         if (($urandom % 8) == 0)
            step(1, $urandom, rnd_vec(), rnd_vec(), rnd_vec(), "R9");
      end
      idle();
      idle();
      @(negedge clk);
      compare();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule